// File: doc/BRIEF.md
# Write-Levelling Lane Delay Adjuster

This block holds the write-levelling delay of every byte lane of every memory module on a channel: nine lanes per module (eight data lanes and one check-bit lane), each kept as a wide gross part and a 5-bit fine part. The gross part is wider in storage than the PHY's 2-bit field. Software or a training sequencer loads starting values through a write port and reads any lane back through a combinational read port.

Before a training pass, a seed run walks the lanes of one module in order. It builds the three words the PHY is loaded with: a low word for lanes 0 to 3, a high word for lanes 4 to 7, and an 8-bit check-lane word. Any stored gross value too large for the PHY field is folded down in the programmed copy only. On a second pass a module that is flagged for it can have a fixed amount taken off each stored delay first. After training, a result run takes the PHY's three result words. It restores the gross offset that the fold removed, clamps a result that wrapped below zero, and writes the corrected delays back into storage.

The controller is a four-state machine. **IDLE** waits. From there, `seed_go` leads to **SEED** and `res_go` leads to **RESULT**. SEED and RESULT each spend one cycle per lane and move to **DONE** after lane 8. DONE lasts one cycle and then returns to IDLE.

Top module: `wl_lane_adjuster`

## Requirements
- R1: After reset, `busy` and `done` are low, all three seed words are zero and every stored lane reads back as gross 0, fine 0.
- R2: While idle, a cycle with `wr_en` high stores `wr_gross`/`wr_fine` at (`wr_dimm`, `wr_lane`). From the next cycle the read port returns that value for that address.
- R3: A seed byte has bit 7 zero, the PHY gross in bits [6:5] and the fine value in bits [4:0]. Lane n<4 sits at bits [8n+7:8n] of `seed_lo`, lane n in 4..7 at bits [8(n-4)+7:8(n-4)] of `seed_hi`, and lane 8 is `seed_ecc`.
- R4: In a seed run, a stored gross of 0 to 2 is programmed unchanged. A stored gross of 3 or more is programmed as 1 when odd and 2 when even, and the stored gross keeps its full value.
- R5: With `pass2_adj` high at `seed_go`, each lane's combined value gross*32+fine has 12 subtracted, saturating at 0. The result is written back to storage and is the value that gets programmed.
- R6: In a result run, a lane whose stored gross s is 3 or more gets the new gross trained+s−fold(s), saturating at 15. Here fold(s) is the programmed value from R4 and trained is bits [6:5] of the lane's result byte.
- R7: In a result run, a lane with stored gross 0 and trained gross 3 gets gross 0.
- R8: In a result run, every other lane takes the trained gross as it is. Every lane takes bits [4:0] of its result byte as the new fine value, and bit 7 of a result byte has no effect.
- R9: Lanes are handled in the order 0 to 8. `done` is a one-cycle pulse 10 cycles after the edge that accepts the start, with the seed words final while it is high. `busy` stays high from acceptance through `done` and is low in the cycle after.
- R10: While `busy` is high, `wr_en`, `seed_go` and `res_go` are ignored. When `seed_go` and `res_go` arrive together in idle, the seed run is taken.
- R11: The result words are captured at the accepting edge. Changing them during the run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store one lane's delay (idle only) |
| wr_dimm | input | 2 | Module index for the store |
| wr_lane | input | 4 | Lane index for the store (0 to 8) |
| wr_gross | input | 4 | Gross delay to store |
| wr_fine | input | 5 | Fine delay to store |
| op_dimm | input | 2 | Module that a seed or result run works on |
| seed_go | input | 1 | Start a seed run |
| pass2_adj | input | 1 | Apply the second-pass subtraction in this seed run |
| res_go | input | 1 | Start a result run |
| res_lo | input | 32 | PHY result bytes of lanes 0 to 3 |
| res_hi | input | 32 | PHY result bytes of lanes 4 to 7 |
| res_ecc | input | 8 | PHY result byte of lane 8 |
| rd_dimm | input | 2 | Module index for readback |
| rd_lane | input | 4 | Lane index for readback |
| rd_gross | output | 4 | Stored gross of the addressed lane |
| rd_fine | output | 5 | Stored fine of the addressed lane |
| seed_lo | output | 32 | Programmed bytes of lanes 0 to 3 |
| seed_hi | output | 32 | Programmed bytes of lanes 4 to 7 |
| seed_ecc | output | 8 | Programmed byte of lane 8 |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Inputs are driven on the falling edge. A start driven at a falling edge where the bench's edge counter reads n is taken at the next rising edge. `done` must then be seen at the falling edge where the counter reads n+10, and the seed words are compared in that same half cycle. The driver records this due count with each expected item. The monitor rejects a `done` that comes early, late, or with no item queued. Stored lanes come back through the combinational read port, so every write-back is checked on a falling edge after `busy` has dropped. This includes the lanes a result run rewrote and the lanes that an ignored write or a changed result word would have touched.

// File: rtl/wl_pkg.sv
package wl_pkg;

    // PHY-side field widths of one lane byte
    localparam int WL_FINE_W      = 5;
    localparam int WL_PHY_GROSS_W = 2;
    localparam int WL_BYTE_W      = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_RESULT,
        ST_DONE
    } wl_state_e;

    // Gross value the PHY is programmed with for a stored gross g
    function automatic logic [WL_PHY_GROSS_W-1:0] fold_gross(input logic [7:0] g);
        if (g >= 8'd3) begin
            return g[0] ? 2'd1 : 2'd2;
        end
        return g[1:0];
    endfunction

endpackage

// File: rtl/wl_delay_store.sv
module wl_delay_store
    import wl_pkg::*;
#(
    parameter int NUM_DIMMS = 4,
    parameter int NUM_LANES = 9,
    parameter int GROSS_W   = 4,
    localparam int DIMM_W   = $clog2(NUM_DIMMS),
    localparam int LANE_W   = $clog2(NUM_LANES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [DIMM_W-1:0]  w_dimm,
    input  logic [LANE_W-1:0]  w_lane,
    input  logic [GROSS_W-1:0] w_gross,
    input  logic [WL_FINE_W-1:0] w_fine,
    input  logic [DIMM_W-1:0]  a_dimm,
    input  logic [LANE_W-1:0]  a_lane,
    output logic [GROSS_W-1:0] a_gross,
    output logic [WL_FINE_W-1:0] a_fine,
    input  logic [DIMM_W-1:0]  b_dimm,
    input  logic [LANE_W-1:0]  b_lane,
    output logic [GROSS_W-1:0] b_gross,
    output logic [WL_FINE_W-1:0] b_fine
);

    localparam int ENTRY_W = GROSS_W + WL_FINE_W;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(NUM_LANES - 1);

    logic [ENTRY_W-1:0] mem_q [NUM_DIMMS][NUM_LANES];
    logic [ENTRY_W-1:0] a_word;
    logic [ENTRY_W-1:0] b_word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < NUM_DIMMS; d++) begin
                for (int l = 0; l < NUM_LANES; l++) begin
                    mem_q[d][l] <= '0;
                end
            end
        end else if (we && (w_lane <= LAST_LANE)) begin
            mem_q[w_dimm][w_lane] <= {w_gross, w_fine};
        end
    end

    always_comb begin
        a_word = '0;
        b_word = '0;
        if (a_lane <= LAST_LANE) a_word = mem_q[a_dimm][a_lane];
        if (b_lane <= LAST_LANE) b_word = mem_q[b_dimm][b_lane];
    end

    assign a_gross = a_word[ENTRY_W-1:WL_FINE_W];
    assign a_fine  = a_word[WL_FINE_W-1:0];
    assign b_gross = b_word[ENTRY_W-1:WL_FINE_W];
    assign b_fine  = b_word[WL_FINE_W-1:0];

endmodule

// File: rtl/wl_seed_lane.sv
module wl_seed_lane
    import wl_pkg::*;
#(
    parameter int GROSS_W    = 4,
    parameter int ADJ_OFFSET = 12
) (
    input  logic [GROSS_W-1:0]   st_gross,
    input  logic [WL_FINE_W-1:0] st_fine,
    input  logic                 adj_en,
    output logic [GROSS_W-1:0]   new_gross,
    output logic [WL_FINE_W-1:0] new_fine,
    output logic [WL_BYTE_W-1:0] lane_byte
);

    localparam int COMB_W = GROSS_W + WL_FINE_W;
    localparam logic [COMB_W-1:0] OFS = COMB_W'(ADJ_OFFSET);

    logic [COMB_W-1:0]         comb_in;
    logic [COMB_W-1:0]         comb_out;
    logic [WL_PHY_GROSS_W-1:0] phy_gross;

    always_comb begin
        comb_in  = {st_gross, st_fine};
        comb_out = comb_in;
        if (adj_en) begin
            comb_out = (comb_in > OFS) ? (comb_in - OFS) : '0;
        end
        new_gross = comb_out[COMB_W-1:WL_FINE_W];
        new_fine  = comb_out[WL_FINE_W-1:0];
        phy_gross = fold_gross(8'(new_gross));
        lane_byte = {1'b0, phy_gross, new_fine};
    end

endmodule

// File: rtl/wl_result_lane.sv
module wl_result_lane
    import wl_pkg::*;
#(
    parameter int GROSS_W = 4
) (
    input  logic [GROSS_W-1:0]   seed_gross,
    input  logic [6:0]           trained,
    output logic [GROSS_W-1:0]   new_gross,
    output logic [WL_FINE_W-1:0] new_fine
);

    logic [WL_PHY_GROSS_W-1:0] tr_gross;
    logic [GROSS_W:0]          restored;

    always_comb begin
        tr_gross = trained[6:5];
        new_fine = trained[WL_FINE_W-1:0];
        restored = {1'b0, seed_gross} + (GROSS_W+1)'(tr_gross)
                 - (GROSS_W+1)'(fold_gross(8'(seed_gross)));
        if (seed_gross >= GROSS_W'(3)) begin
            new_gross = restored[GROSS_W] ? '1 : restored[GROSS_W-1:0];
        end else if ((seed_gross == '0) && (tr_gross == 2'd3)) begin
            new_gross = '0;
        end else begin
            new_gross = GROSS_W'(tr_gross);
        end
    end

endmodule

// File: rtl/wl_lane_adjuster.sv
module wl_lane_adjuster
    import wl_pkg::*;
#(
    parameter int NUM_DIMMS  = 4,
    parameter int NUM_LANES  = 9,
    parameter int GROSS_W    = 4,
    parameter int ADJ_OFFSET = 12,
    localparam int DIMM_W    = $clog2(NUM_DIMMS),
    localparam int LANE_W    = $clog2(NUM_LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DIMM_W-1:0]    wr_dimm,
    input  logic [LANE_W-1:0]    wr_lane,
    input  logic [GROSS_W-1:0]   wr_gross,
    input  logic [WL_FINE_W-1:0] wr_fine,
    input  logic [DIMM_W-1:0]    op_dimm,
    input  logic                 seed_go,
    input  logic                 pass2_adj,
    input  logic                 res_go,
    input  logic [31:0]          res_lo,
    input  logic [31:0]          res_hi,
    input  logic [7:0]           res_ecc,
    input  logic [DIMM_W-1:0]    rd_dimm,
    input  logic [LANE_W-1:0]    rd_lane,
    output logic [GROSS_W-1:0]   rd_gross,
    output logic [WL_FINE_W-1:0] rd_fine,
    output logic [31:0]          seed_lo,
    output logic [31:0]          seed_hi,
    output logic [7:0]           seed_ecc,
    output logic                 busy,
    output logic                 done
);

    localparam logic [LANE_W-1:0] LAST_LANE   = LANE_W'(NUM_LANES - 1);
    localparam logic [LANE_W-1:0] HI_FIRST    = LANE_W'(4);
    localparam logic [LANE_W-1:0] ECC_LANE    = LANE_W'(8);

    wl_state_e state_q, state_d;

    logic [LANE_W-1:0]    lane_q;
    logic [DIMM_W-1:0]    dimm_q;
    logic                 adj_q;
    logic [31:0]          res_lo_q, res_hi_q;
    logic [7:0]           res_ecc_q;
    logic [31:0]          seed_lo_q, seed_hi_q;
    logic [7:0]           seed_ecc_q;

    // storage ports
    logic                 st_we;
    logic [DIMM_W-1:0]    st_w_dimm;
    logic [LANE_W-1:0]    st_w_lane;
    logic [GROSS_W-1:0]   st_w_gross;
    logic [WL_FINE_W-1:0] st_w_fine;
    logic [GROSS_W-1:0]   cur_gross;
    logic [WL_FINE_W-1:0] cur_fine;

    // lane datapath
    logic [GROSS_W-1:0]   sd_gross;
    logic [WL_FINE_W-1:0] sd_fine;
    logic [WL_BYTE_W-1:0] sd_byte;
    logic [GROSS_W-1:0]   rs_gross;
    logic [WL_FINE_W-1:0] rs_fine;
    logic [6:0]           trained;
    logic [4:0]           slot;

    logic                 idle;
    logic                 take_seed;
    logic                 take_res;
    logic                 unused_msbs;

    assign idle      = (state_q == ST_IDLE);
    assign take_seed = idle && seed_go;
    assign take_res  = idle && res_go && !seed_go;
    assign slot      = {lane_q[1:0], 3'b000};

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (seed_go)     state_d = ST_SEED;
                else if (res_go) state_d = ST_RESULT;
            end
            ST_SEED, ST_RESULT: begin
                if (lane_q == LAST_LANE) state_d = ST_DONE;
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy = (state_q != ST_IDLE);
        done = (state_q == ST_DONE);
    end

    assign seed_lo  = seed_lo_q;
    assign seed_hi  = seed_hi_q;
    assign seed_ecc = seed_ecc_q;

    // ---------------- run registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q     <= '0;
            dimm_q     <= '0;
            adj_q      <= 1'b0;
            res_lo_q   <= '0;
            res_hi_q   <= '0;
            res_ecc_q  <= '0;
            seed_lo_q  <= '0;
            seed_hi_q  <= '0;
            seed_ecc_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    lane_q <= '0;
                    if (take_seed) begin
                        dimm_q     <= op_dimm;
                        adj_q      <= pass2_adj;
                        seed_lo_q  <= '0;
                        seed_hi_q  <= '0;
                        seed_ecc_q <= '0;
                    end else if (take_res) begin
                        dimm_q    <= op_dimm;
                        adj_q     <= 1'b0;
                        res_lo_q  <= res_lo;
                        res_hi_q  <= res_hi;
                        res_ecc_q <= res_ecc;
                    end
                end
                ST_SEED: begin
                    if (lane_q < HI_FIRST)       seed_lo_q[slot +: 8] <= sd_byte;
                    else if (lane_q < ECC_LANE)  seed_hi_q[slot +: 8] <= sd_byte;
                    else                         seed_ecc_q           <= sd_byte;
                    lane_q <= lane_q + 1'b1;
                end
                ST_RESULT: lane_q <= lane_q + 1'b1;
                ST_DONE:   lane_q <= '0;
                default:   lane_q <= '0;
            endcase
        end
    end

    // ---------------- trained byte select ----------------
    always_comb begin
        if (lane_q < HI_FIRST)      trained = res_lo_q[slot +: 7];
        else if (lane_q < ECC_LANE) trained = res_hi_q[slot +: 7];
        else                        trained = res_ecc_q[6:0];
    end

    assign unused_msbs = ^{res_lo_q[31], res_lo_q[23], res_lo_q[15], res_lo_q[7],
                           res_hi_q[31], res_hi_q[23], res_hi_q[15], res_hi_q[7],
                           res_ecc_q[7]};

    // ---------------- storage write mux ----------------
    always_comb begin
        st_we      = 1'b0;
        st_w_dimm  = wr_dimm;
        st_w_lane  = wr_lane;
        st_w_gross = wr_gross;
        st_w_fine  = wr_fine;
        unique case (state_q)
            ST_IDLE:   st_we = wr_en;
            ST_SEED: begin
                st_we      = 1'b1;
                st_w_dimm  = dimm_q;
                st_w_lane  = lane_q;
                st_w_gross = sd_gross;
                st_w_fine  = sd_fine;
            end
            ST_RESULT: begin
                st_we      = 1'b1;
                st_w_dimm  = dimm_q;
                st_w_lane  = lane_q;
                st_w_gross = rs_gross;
                st_w_fine  = rs_fine;
            end
            default:   st_we = 1'b0;
        endcase
    end

    wl_delay_store #(
        .NUM_DIMMS (NUM_DIMMS),
        .NUM_LANES (NUM_LANES),
        .GROSS_W   (GROSS_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (st_we),
        .w_dimm  (st_w_dimm),
        .w_lane  (st_w_lane),
        .w_gross (st_w_gross),
        .w_fine  (st_w_fine),
        .a_dimm  (rd_dimm),
        .a_lane  (rd_lane),
        .a_gross (rd_gross),
        .a_fine  (rd_fine),
        .b_dimm  (dimm_q),
        .b_lane  (lane_q),
        .b_gross (cur_gross),
        .b_fine  (cur_fine)
    );

    wl_seed_lane #(
        .GROSS_W    (GROSS_W),
        .ADJ_OFFSET (ADJ_OFFSET)
    ) u_seed (
        .st_gross  (cur_gross),
        .st_fine   (cur_fine),
        .adj_en    (adj_q),
        .new_gross (sd_gross),
        .new_fine  (sd_fine),
        .lane_byte (sd_byte)
    );

    wl_result_lane #(
        .GROSS_W (GROSS_W)
    ) u_result (
        .seed_gross (cur_gross),
        .trained    (trained),
        .new_gross  (rs_gross),
        .new_fine   (rs_fine)
    );

endmodule

// File: rtl/wl_lane_adjuster_chk.sv
module wl_lane_adjuster_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        seed_go,
    input logic        res_go,
    input logic        busy,
    input logic        done,
    input logic [31:0] seed_lo,
    input logic [31:0] seed_hi,
    input logic [7:0]  seed_ecc
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_GO_STARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (seed_go || res_go)) |=> busy); // R9

    AST_RUN_NOT_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R10

    AST_SEED_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!seed_lo[7] && !seed_lo[15] && !seed_lo[23] && !seed_lo[31] &&
                  !seed_hi[7] && !seed_hi[15] && !seed_hi[23] && !seed_hi[31] &&
                  !seed_ecc[7])); // R3

    AST_FOLDED_GROSS: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (seed_lo[6:5] != 2'd3 && seed_lo[14:13] != 2'd3 &&
                  seed_lo[22:21] != 2'd3 && seed_lo[30:29] != 2'd3 &&
                  seed_hi[6:5] != 2'd3 && seed_hi[14:13] != 2'd3 &&
                  seed_hi[22:21] != 2'd3 && seed_hi[30:29] != 2'd3 &&
                  seed_ecc[6:5] != 2'd3)); // R4

endmodule

bind wl_lane_adjuster wl_lane_adjuster_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .seed_go  (seed_go),
    .res_go   (res_go),
    .busy     (busy),
    .done     (done),
    .seed_lo  (seed_lo),
    .seed_hi  (seed_hi),
    .seed_ecc (seed_ecc)
);

// File: tb/tb_wl_lane_adjuster.sv
`timescale 1ns/1ps
module tb_wl_lane_adjuster;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_dimm = '0;
    logic [3:0]  wr_lane = '0;
    logic [3:0]  wr_gross = '0;
    logic [4:0]  wr_fine = '0;
    logic [1:0]  op_dimm = '0;
    logic        seed_go = 1'b0;
    logic        pass2_adj = 1'b0;
    logic        res_go = 1'b0;
    logic [31:0] res_lo = '0;
    logic [31:0] res_hi = '0;
    logic [7:0]  res_ecc = '0;
    logic [1:0]  rd_dimm = '0;
    logic [3:0]  rd_lane = '0;
    logic [3:0]  rd_gross;
    logic [4:0]  rd_fine;
    logic [31:0] seed_lo, seed_hi;
    logic [7:0]  seed_ecc;
    logic        busy, done;

    always #2 clk = ~clk; // 250 MHz

    wl_lane_adjuster dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_dimm(wr_dimm),
        .wr_lane(wr_lane), .wr_gross(wr_gross), .wr_fine(wr_fine),
        .op_dimm(op_dimm), .seed_go(seed_go), .pass2_adj(pass2_adj),
        .res_go(res_go), .res_lo(res_lo), .res_hi(res_hi), .res_ecc(res_ecc),
        .rd_dimm(rd_dimm), .rd_lane(rd_lane), .rd_gross(rd_gross),
        .rd_fine(rd_fine), .seed_lo(seed_lo), .seed_hi(seed_hi),
        .seed_ecc(seed_ecc), .busy(busy), .done(done)
    );

    typedef struct {
        bit          is_seed;
        logic [31:0] lo;
        logic [31:0] hi;
        logic [7:0]  ecc;
        int          due;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   reported = 1'b0;
    int   m_g [4][9];
    int   m_f [4][9];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    function automatic int tb_fold(input int g);
        if (g < 3) return g;
        return (g % 2 == 1) ? 1 : 2;
    endfunction

    // ---------------- monitor ----------------
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R9 done without a started run", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(cyc == e.due, {"R9 done cycle ", e.tag}, cyc, e.due);
                if (e.is_seed) begin
                    chk(seed_lo == e.lo, {"R3 seed_lo ", e.tag}, seed_lo, e.lo);
                    chk(seed_hi == e.hi, {"R3 seed_hi ", e.tag}, seed_hi, e.hi);
                    chk(seed_ecc == e.ecc, {"R3 seed_ecc ", e.tag}, seed_ecc, e.ecc);
                end
            end
        end
    end

    // ---------------- driver tasks ----------------
    task automatic wr(input int d, input int l, input int g, input int f);
        @(negedge clk);
        wr_en = 1'b1; wr_dimm = 2'(d); wr_lane = 4'(l);
        wr_gross = 4'(g); wr_fine = 5'(f);
        m_g[d][l] = g; m_f[d][l] = f;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic seed_run(input int d, input bit adj, input bit with_res, input string tag);
        exp_t e;
        e.is_seed = 1'b1; e.lo = '0; e.hi = '0; e.ecc = '0; e.tag = tag;
        for (int l = 0; l < 9; l++) begin
            int g, f, b;
            g = m_g[d][l]; f = m_f[d][l];
            if (adj) begin
                int c;
                c = g * 32 + f;
                c = (c > 12) ? c - 12 : 0;
                g = c / 32; f = c % 32;
                m_g[d][l] = g; m_f[d][l] = f;
            end
            b = tb_fold(g) * 32 + f;
            if (l < 4)      e.lo[8*l +: 8] = 8'(b);
            else if (l < 8) e.hi[8*(l-4) +: 8] = 8'(b);
            else            e.ecc = 8'(b);
        end
        @(negedge clk);
        e.due = cyc + 10;
        q.push_back(e);
        op_dimm = 2'(d); pass2_adj = adj; seed_go = 1'b1; res_go = with_res;
        @(negedge clk);
        seed_go = 1'b0; res_go = 1'b0; pass2_adj = 1'b0;
        wait_idle();
    endtask

    task automatic res_run(input int d, input logic [31:0] lo, input logic [31:0] hi,
                           input logic [7:0] ecc, input bit disturb, input string tag);
        exp_t e;
        e.is_seed = 1'b0; e.lo = '0; e.hi = '0; e.ecc = '0; e.tag = tag;
        for (int l = 0; l < 9; l++) begin
            logic [7:0] b;
            int s, tg, ng;
            if (l < 4)      b = lo[8*l +: 8];
            else if (l < 8) b = hi[8*(l-4) +: 8];
            else            b = ecc;
            s = m_g[d][l]; tg = int'(b[6:5]);
            if (s >= 3) begin
                ng = tg + s - tb_fold(s);
                if (ng > 15) ng = 15;
            end else if (s == 0 && tg == 3) ng = 0;
            else ng = tg;
            m_g[d][l] = ng; m_f[d][l] = int'(b[4:0]);
        end
        @(negedge clk);
        e.due = cyc + 10;
        q.push_back(e);
        op_dimm = 2'(d); res_lo = lo; res_hi = hi; res_ecc = ecc; res_go = 1'b1;
        @(negedge clk);
        res_go = 1'b0;
        if (disturb) begin
            // R10 / R11: stimulus while busy must change nothing
            res_lo = 32'hFFFF_FFFF; res_hi = 32'hFFFF_FFFF; res_ecc = 8'hFF;
            wr_en = 1'b1; wr_dimm = 2'(d); wr_lane = 4'd0; wr_gross = 4'd9; wr_fine = 5'd9;
            seed_go = 1'b1; res_go = 1'b1;
            @(negedge clk);
            @(negedge clk);
            wr_en = 1'b0; seed_go = 1'b0; res_go = 1'b0;
        end
        wait_idle();
    endtask

    task automatic check_store(input int d, input string tag);
        for (int l = 0; l < 9; l++) begin
            @(negedge clk);
            rd_dimm = 2'(d); rd_lane = 4'(l);
            #1;
            chk(rd_gross == 4'(m_g[d][l]), {tag, " gross"}, rd_gross, m_g[d][l]);
            chk(rd_fine == 5'(m_f[d][l]), {tag, " fine"}, rd_fine, m_f[d][l]);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog expired", 1, 0);
        report();
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int d = 0; d < 4; d++)
            for (int l = 0; l < 9; l++) begin
                m_g[d][l] = 0; m_f[d][l] = 0;
            end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(seed_lo == 0 && seed_hi == 0 && seed_ecc == 0, "R1 seed words", seed_lo, 0);
        check_store(2, "R1 store");

        // R2 stores, readback
        begin
            int gs[9] = '{0, 1, 2, 3, 4, 5, 6, 7, 15};
            int fs[9] = '{31, 3, 10, 0, 31, 7, 1, 16, 5};
            for (int l = 0; l < 9; l++) wr(0, l, gs[l], fs[l]);
        end
        check_store(0, "R2 write readback");

        // R3 R4 plain seed run; stored gross unchanged
        seed_run(0, 1'b0, 1'b0, "R4 fold");
        check_store(0, "R4 stored gross kept");

        // R5 second-pass subtraction and write-back
        seed_run(0, 1'b1, 1'b0, "R5 pass2");
        check_store(0, "R5 write-back");
        wr(3, 0, 0, 5);
        seed_run(3, 1'b1, 1'b0, "R5 saturate");
        check_store(3, "R5 saturate store");

        // R6 R7 R8 result correction
        begin
            int gs[9] = '{0, 0, 3, 4, 15, 2, 6, 1, 0};
            for (int l = 0; l < 9; l++) wr(1, l, gs[l], 0);
        end
        res_run(1, 32'h6231_C864, 32'h010C_607F, 8'h09, 1'b0, "R6 result");
        check_store(1, "R6 R7 R8 corrected store");

        // R10 R11 disturbance during a run
        res_run(2, 32'h2143_6587, 32'h7F60_A3E1, 8'hC6, 1'b1, "R11 captured");
        check_store(2, "R10 R11 store after disturbance");

        // R10 simultaneous starts: seed run wins, storage untouched
        seed_run(1, 1'b0, 1'b1, "R10 priority");
        check_store(1, "R10 priority store");

        repeat (12) @(negedge clk);
        chk(q.size() == 0, "R9 outstanding runs", q.size(), 0);
        chk(busy == 1'b0, "R9 idle at end", busy, 0);
        report();
    end

endmodule